// File: doc/BRIEF.md
# System Register Access Trap Arbiter

This block judges a single system-register access to the trace claim-set register and decides whether it may go ahead. A requester presents the five encoding fields of the instruction, the current exception level, a read/write flag and a group of control inputs. These inputs describe the debug state, which higher levels are present or enabled, the trace-access trap bit at each level, and separate fine-grained read and write trap bits. When the encoding matches, a fixed priority order picks one outcome: permitted, undefined, or a trap routed to EL1, EL2 or EL3. The order depends on the exception level.

The verdict is registered and appears one cycle after the request is presented. Any trap carries a syndrome exception class. An access whose encoding does not match is flagged as no-match, and no trap is raised for it.

A two-state response machine drives the timing. ST_IDLE moves to ST_RESP when a request is valid (transition T_ACCEPT). ST_RESP stays in ST_RESP on another valid request (T_CHAIN) and returns to ST_IDLE when there is none (T_DRAIN).

Top module: `access_trap_arbiter`

## Requirements
- R1: A response (rsp_valid=1) appears exactly one clock after each cycle with req_valid=1, and only then. Back-to-back requests give back-to-back responses. Outside a response, and after reset, rsp_valid, rsp_code, rsp_nomatch and rsp_class are all 0.
- R2: The matching encoding is op0=2'b10, op1=3'b001, crn=4'b0111, crm=4'b1000, op2=3'b110. Any other encoding responds with rsp_nomatch=1, rsp_code=0 and rsp_class=0, whatever the level and control inputs.
- R3: A matching access from level 0 responds undefined. The result codes are 0 permitted, 1 undefined, 2 trap to EL1, 3 trap to EL2 and 4 trap to EL3.
- R4: At levels 1 and 2, undefined takes precedence over every other check when all of these hold together: halted, el3_present, sec_dbg_off, el3_prio_opt and tta_el3.
- R5: At level 1, tta_el1 gives a trap to EL1 ahead of all remaining checks.
- R6: At level 1, tta_el2 gives a trap to EL2 only when el2_enabled is 1. With el2_enabled at 0 it has no effect.
- R7: At level 1, a fine-grained trap to EL2 happens when el2_enabled is 1, either el3_present is 0 or fgt_enable is 1, and the direction bit is set. A read uses fgt_rd and a write uses fgt_wr; the other direction's bit is ignored.
- R8: At levels 1 and 2, the last check is el3_present with tta_el3. It gives undefined if halted and sec_dbg_off are both set, and a trap to EL3 otherwise.
- R9: At level 2, tta_el2 traps to EL2 regardless of el2_enabled. At this level tta_el1, fgt_rd and fgt_wr have no effect.
- R10: At level 3, tta_el3 traps to EL3 even when halted, sec_dbg_off and el3_prio_opt are all set. Level 3 never responds undefined.
- R11: Every trap code (2, 3 or 4) carries rsp_class=6'h18. Every other response carries rsp_class=0.
- R12: A matching access at levels 1 to 3 for which no check fires is permitted (code 0, rsp_nomatch=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_el | input | 2 | Current exception level |
| enc_op0 | input | 2 | Encoding field op0 |
| enc_op1 | input | 3 | Encoding field op1 |
| enc_crn | input | 4 | Encoding field CRn |
| enc_crm | input | 4 | Encoding field CRm |
| enc_op2 | input | 3 | Encoding field op2 |
| halted | input | 1 | Core is in halted debug state |
| sec_dbg_off | input | 1 | Secure debug disabled |
| el3_prio_opt | input | 1 | Implementation option: EL3 trap has priority when secure debug is off |
| el2_enabled | input | 1 | EL2 enabled in the current state |
| el3_present | input | 1 | EL3 implemented |
| fgt_enable | input | 1 | Fine-grained trap enable controlled from EL3 |
| tta_el1 | input | 1 | Trace-access trap bit controlled at EL1 |
| tta_el2 | input | 1 | Trace-access trap bit controlled at EL2 |
| tta_el3 | input | 1 | Trace-access trap bit controlled at EL3 |
| fgt_rd | input | 1 | Fine-grained read trap bit |
| fgt_wr | input | 1 | Fine-grained write trap bit |
| rsp_valid | output | 1 | Response present |
| rsp_code | output | 3 | Outcome code |
| rsp_nomatch | output | 1 | Encoding did not match |
| rsp_class | output | 6 | Syndrome exception class |

## Verification
The functions that meet in one cycle are the halted-debug undefined check and the trap checks further down the order. The bench raises the full first-undefined condition together with tta_el1 at level 1, and again together with tta_el2 at level 2, then with one term of the condition dropped. The outcome must move from undefined to the lower trap exactly when that one term goes away. A second collision puts the fine-grained bit of the opposite direction beside a matching request, and a third presents two requests in consecutive cycles so that a new verdict is captured in the same cycle the previous one is shown. Each verdict is judged at the outputs one edge after its request.

// File: rtl/trap_arb_pkg.sv
package trap_arb_pkg;

    localparam int EL_W   = 2;
    localparam int CODE_W = 3;
    localparam int EC_W   = 6;
    localparam logic [EC_W-1:0] EC_TRACE_TRAP = 6'h18;

    typedef enum logic [CODE_W-1:0] {
        RES_PERMIT   = 3'd0,
        RES_UNDEF    = 3'd1,
        RES_TRAP_EL1 = 3'd2,
        RES_TRAP_EL2 = 3'd3,
        RES_TRAP_EL3 = 3'd4
    } access_res_e;

    typedef struct packed {
        logic halted;
        logic sec_dbg_off;
        logic el3_prio_opt;
        logic el2_enabled;
        logic el3_present;
        logic fgt_enable;
        logic tta_el1;
        logic tta_el2;
        logic tta_el3;
        logic fgt_rd;
        logic fgt_wr;
    } trap_ctl_t;

    function automatic logic is_trap(input access_res_e r);
        return (r == RES_TRAP_EL1) || (r == RES_TRAP_EL2) || (r == RES_TRAP_EL3);
    endfunction

endpackage

// File: rtl/enc_match.sv
module enc_match #(
    parameter logic [1:0] OP0 = 2'b10,
    parameter logic [2:0] OP1 = 3'b001,
    parameter logic [3:0] CRN = 4'b0111,
    parameter logic [3:0] CRM = 4'b1000,
    parameter logic [2:0] OP2 = 3'b110
) (
    input  logic [1:0] op0,
    input  logic [2:0] op1,
    input  logic [3:0] crn,
    input  logic [3:0] crm,
    input  logic [2:0] op2,
    output logic       hit
);
    localparam int ENC_W = 16;
    localparam logic [ENC_W-1:0] ENC_REF = {OP0, OP1, CRN, CRM, OP2};

    logic [ENC_W-1:0] enc_in;

    always_comb begin
        enc_in = {op0, op1, crn, crm, op2};
        hit    = (enc_in == ENC_REF);
    end
endmodule

// File: rtl/trap_prio_eval.sv
module trap_prio_eval
    import trap_arb_pkg::*;
(
    input  logic [EL_W-1:0] el,
    input  logic            is_write,
    input  trap_ctl_t       ctl,
    output access_res_e     result
);
    logic first_undef;
    logic fg_dir_bit;
    logic fg_route_ok;
    logic last_el3_hit;
    logic last_undef;

    always_comb begin
        // Halted-debug undefined case checked first at levels 1 and 2
        first_undef  = ctl.halted & ctl.el3_present & ctl.sec_dbg_off &
                       ctl.el3_prio_opt & ctl.tta_el3;
        fg_dir_bit   = is_write ? ctl.fgt_wr : ctl.fgt_rd;
        fg_route_ok  = ctl.el2_enabled & (~ctl.el3_present | ctl.fgt_enable);
        last_el3_hit = ctl.el3_present & ctl.tta_el3;
        last_undef   = ctl.halted & ctl.sec_dbg_off;
    end

    always_comb begin
        result = RES_PERMIT;
        unique case (el)
            2'd0: result = RES_UNDEF;
            2'd1: begin
                if (first_undef)                          result = RES_UNDEF;
                else if (ctl.tta_el1)                     result = RES_TRAP_EL1;
                else if (ctl.el2_enabled && ctl.tta_el2)  result = RES_TRAP_EL2;
                else if (fg_route_ok && fg_dir_bit)       result = RES_TRAP_EL2;
                else if (last_el3_hit)                    result = last_undef ? RES_UNDEF : RES_TRAP_EL3;
                else                                      result = RES_PERMIT;
            end
            2'd2: begin
                if (first_undef)                          result = RES_UNDEF;
                else if (ctl.tta_el2)                     result = RES_TRAP_EL2;
                else if (last_el3_hit)                    result = last_undef ? RES_UNDEF : RES_TRAP_EL3;
                else                                      result = RES_PERMIT;
            end
            2'd3: result = ctl.tta_el3 ? RES_TRAP_EL3 : RES_PERMIT;
            default: result = RES_UNDEF;
        endcase
    end

    always_comb begin
        if (el == 2'd3) begin
            AST_EL3_NEVER_UNDEF: assert (result != RES_UNDEF); // R10
        end
        if (el == 2'd0) begin
            AST_EL0_ALWAYS_UNDEF: assert (result == RES_UNDEF); // R3
        end
    end
endmodule

// File: rtl/rsp_fsm.sv
module rsp_fsm
    import trap_arb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              hit,
    input  access_res_e       verdict,
    output logic              rsp_valid,
    output logic [CODE_W-1:0] rsp_code,
    output logic              rsp_nomatch,
    output logic [EC_W-1:0]   rsp_class
);
    typedef enum logic {ST_IDLE = 1'b0, ST_RESP = 1'b1} rsp_state_e;

    rsp_state_e        state_q, state_d;
    logic [CODE_W-1:0] code_q;
    logic              nomatch_q;
    logic [EC_W-1:0]   class_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid)  state_d = ST_RESP;   // T_ACCEPT
            ST_RESP: if (!req_valid) state_d = ST_IDLE;   // T_DRAIN, else T_CHAIN
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !req_valid) begin
            code_q    <= '0;
            nomatch_q <= 1'b0;
            class_q   <= '0;
        end else if (!hit) begin
            code_q    <= RES_PERMIT;
            nomatch_q <= 1'b1;
            class_q   <= '0;
        end else begin
            code_q    <= verdict;
            nomatch_q <= 1'b0;
            class_q   <= is_trap(verdict) ? EC_TRACE_TRAP : '0;
        end
    end

    always_comb begin
        rsp_valid   = 1'b0;
        rsp_code    = '0;
        rsp_nomatch = 1'b0;
        rsp_class   = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RESP: begin
                rsp_valid   = 1'b1;
                rsp_code    = code_q;
                rsp_nomatch = nomatch_q;
                rsp_class   = class_q;
            end
            default: ;
        endcase
    end

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R1
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R1
    AST_NOMATCH_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !hit) |=> (rsp_nomatch && rsp_code == '0 && rsp_class == '0)); // R2
endmodule

// File: rtl/access_trap_arbiter.sv
module access_trap_arbiter
    import trap_arb_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [1:0]  req_el,
    input  logic [1:0]  enc_op0,
    input  logic [2:0]  enc_op1,
    input  logic [3:0]  enc_crn,
    input  logic [3:0]  enc_crm,
    input  logic [2:0]  enc_op2,
    input  logic        halted,
    input  logic        sec_dbg_off,
    input  logic        el3_prio_opt,
    input  logic        el2_enabled,
    input  logic        el3_present,
    input  logic        fgt_enable,
    input  logic        tta_el1,
    input  logic        tta_el2,
    input  logic        tta_el3,
    input  logic        fgt_rd,
    input  logic        fgt_wr,
    output logic        rsp_valid,
    output logic [2:0]  rsp_code,
    output logic        rsp_nomatch,
    output logic [5:0]  rsp_class
);
    trap_ctl_t   ctl;
    logic        enc_hit;
    access_res_e verdict;

    always_comb begin
        ctl = '{halted:       halted,
                sec_dbg_off:  sec_dbg_off,
                el3_prio_opt: el3_prio_opt,
                el2_enabled:  el2_enabled,
                el3_present:  el3_present,
                fgt_enable:   fgt_enable,
                tta_el1:      tta_el1,
                tta_el2:      tta_el2,
                tta_el3:      tta_el3,
                fgt_rd:       fgt_rd,
                fgt_wr:       fgt_wr};
    end

    enc_match u_match (
        .op0 (enc_op0),
        .op1 (enc_op1),
        .crn (enc_crn),
        .crm (enc_crm),
        .op2 (enc_op2),
        .hit (enc_hit)
    );

    trap_prio_eval u_eval (
        .el       (req_el),
        .is_write (req_write),
        .ctl      (ctl),
        .result   (verdict)
    );

    rsp_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .hit         (enc_hit),
        .verdict     (verdict),
        .rsp_valid   (rsp_valid),
        .rsp_code    (rsp_code),
        .rsp_nomatch (rsp_nomatch),
        .rsp_class   (rsp_class)
    );

    AST_TRAP_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code >= 3'd2) |-> (rsp_class == 6'h18)); // R11
    AST_NONTRAP_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_code < 3'd2) |-> (rsp_class == 6'h0)); // R11
    AST_FIRST_UNDEF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && enc_hit && (req_el == 2'd1 || req_el == 2'd2) && halted &&
         el3_present && sec_dbg_off && el3_prio_opt && tta_el3) |=> (rsp_code == 3'd1)); // R4
    AST_EL1_TRAP_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && enc_hit && req_el == 2'd1 && tta_el1 &&
         !(halted && el3_present && sec_dbg_off && el3_prio_opt && tta_el3)) |=> (rsp_code == 3'd2)); // R5
    AST_EL3_TRAP_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && enc_hit && req_el == 2'd3 && tta_el3) |=> (rsp_code == 3'd4)); // R10
endmodule

// File: tb/sim_access_trap_arbiter.sv
`timescale 1ns/1ps
module sim_access_trap_arbiter;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 0, req_write = 0;
    logic [1:0] req_el = 0;
    logic [1:0] op0 = 2'b10;
    logic [2:0] op1 = 3'b001;
    logic [3:0] crn = 4'b0111;
    logic [3:0] crm = 4'b1000;
    logic [2:0] op2 = 3'b110;
    logic hlt = 0, sdd = 0, opt = 0, e2 = 0, e3p = 0, fge = 0;
    logic t1 = 0, t2 = 0, t3 = 0, fr = 0, fw = 0;
    logic       rsp_valid, rsp_nomatch;
    logic [2:0] rsp_code;
    logic [5:0] rsp_class;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    access_trap_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_el(req_el), .enc_op0(op0), .enc_op1(op1), .enc_crn(crn),
        .enc_crm(crm), .enc_op2(op2), .halted(hlt), .sec_dbg_off(sdd),
        .el3_prio_opt(opt), .el2_enabled(e2), .el3_present(e3p),
        .fgt_enable(fge), .tta_el1(t1), .tta_el2(t2), .tta_el3(t3),
        .fgt_rd(fr), .fgt_wr(fw), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
        .rsp_nomatch(rsp_nomatch), .rsp_class(rsp_class)
    );

    task automatic clear_ctl();
        hlt = 0; sdd = 0; opt = 0; e2 = 0; e3p = 0; fge = 0;
        t1 = 0; t2 = 0; t3 = 0; fr = 0; fw = 0;
        req_write = 0; req_el = 0;
        op0 = 2'b10; op1 = 3'b001; crn = 4'b0111; crm = 4'b1000; op2 = 3'b110;
    endtask

    task automatic expect_out(input string req, input logic v, input logic [2:0] c,
                              input logic nm);
        logic [5:0] cls;
        cls = (v && c >= 3'd2) ? 6'h18 : 6'h0;
        n_chk++;
        if (rsp_valid !== v || rsp_code !== c || rsp_nomatch !== nm || rsp_class !== cls) begin
            n_err++;
            $display("FAIL %s: got v=%0d code=%0d nm=%0d cls=%h, expected v=%0d code=%0d nm=%0d cls=%h",
                     req, rsp_valid, rsp_code, rsp_nomatch, rsp_class, v, c, nm, cls);
        end
    endtask

    // Present one request at a negedge, check the response one edge later.
    task automatic issue(input string req, input logic [2:0] exp_code, input logic exp_nm);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        expect_out(req, 1'b1, exp_code, exp_nm);
        @(negedge clk);
        expect_out({req, " idle"}, 1'b0, 3'd0, 1'b0); // R1
    endtask

    task automatic t_reset();
        expect_out("R1 reset", 1'b0, 3'd0, 1'b0);
    endtask

    task automatic t_nomatch();
        clear_ctl(); req_el = 2'd1; t1 = 1; crm = 4'b1001;
        issue("R2 crm mismatch", 3'd0, 1'b1);
        clear_ctl(); req_el = 2'd0; op2 = 3'b111;
        issue("R2 op2 mismatch el0", 3'd0, 1'b1);
    endtask

    task automatic t_el0();
        clear_ctl(); req_el = 2'd0;
        issue("R3 el0 plain", 3'd1, 1'b0);
        clear_ctl(); req_el = 2'd0; t3 = 1; e3p = 1; req_write = 1;
        issue("R3 el0 with el3 trap", 3'd1, 1'b0);
    endtask

    task automatic t_first_undef();
        clear_ctl(); req_el = 2'd1; hlt = 1; e3p = 1; sdd = 1; opt = 1; t3 = 1; t1 = 1;
        issue("R4 el1 collides with tta_el1", 3'd1, 1'b0);
        opt = 0;
        issue("R5 option off gives el1 trap", 3'd2, 1'b0);
        clear_ctl(); req_el = 2'd2; hlt = 1; e3p = 1; sdd = 1; opt = 1; t3 = 1; t2 = 1;
        issue("R4 el2 collides with tta_el2", 3'd1, 1'b0);
        hlt = 0;
        issue("R9 not halted gives el2 trap", 3'd3, 1'b0);
    endtask

    task automatic t_el1_order();
        clear_ctl(); req_el = 2'd1; t1 = 1; t2 = 1; e2 = 1; t3 = 1; e3p = 1;
        issue("R5 el1 trap beats lower", 3'd2, 1'b0);
        clear_ctl(); req_el = 2'd1; t2 = 1; e2 = 1;
        issue("R6 el2 trap when enabled", 3'd3, 1'b0);
        e2 = 0;
        issue("R6 el2 trap ignored when disabled", 3'd0, 1'b0);
    endtask

    task automatic t_el1_fgt();
        clear_ctl(); req_el = 2'd1; e2 = 1; fr = 1;
        issue("R7 read fg no el3", 3'd3, 1'b0);
        e3p = 1;
        issue("R7 read fg el3 present no enable", 3'd0, 1'b0);
        fge = 1;
        issue("R7 read fg el3 present enabled", 3'd3, 1'b0);
        req_write = 1;
        issue("R7 write ignores read bit", 3'd0, 1'b0);
        fw = 1; fr = 0;
        issue("R7 write fg bit", 3'd3, 1'b0);
        e2 = 0;
        issue("R7 fg ignored el2 disabled", 3'd0, 1'b0);
    endtask

    task automatic t_el3_last();
        clear_ctl(); req_el = 2'd1; e3p = 1; t3 = 1; hlt = 1; sdd = 1;
        issue("R8 el1 halted secure off", 3'd1, 1'b0);
        sdd = 0;
        issue("R8 el1 halted secure on", 3'd4, 1'b0);
        clear_ctl(); req_el = 2'd1; t3 = 1;
        issue("R8 el3 absent no trap", 3'd0, 1'b0);
        clear_ctl(); req_el = 2'd2; e3p = 1; t3 = 1;
        issue("R8 el2 traps to el3", 3'd4, 1'b0);
    endtask

    task automatic t_el2();
        clear_ctl(); req_el = 2'd2; t1 = 1; fr = 1; fw = 1; e2 = 1; fge = 1;
        issue("R9 el2 ignores el1 and fg bits", 3'd0, 1'b0);
        clear_ctl(); req_el = 2'd2; t2 = 1;
        issue("R9 el2 trap without enable", 3'd3, 1'b0);
    endtask

    task automatic t_el3();
        clear_ctl(); req_el = 2'd3; t3 = 1; hlt = 1; sdd = 1; opt = 1; e3p = 1;
        issue("R10 el3 trap despite halted", 3'd4, 1'b0);
        clear_ctl(); req_el = 2'd3; t1 = 1; t2 = 1; e2 = 1; fr = 1;
        issue("R12 el3 permitted", 3'd0, 1'b0);
        clear_ctl(); req_el = 2'd1; req_write = 1; e2 = 1; e3p = 1;
        issue("R12 el1 permitted", 3'd0, 1'b0);
    endtask

    task automatic t_back_to_back();
        clear_ctl(); req_el = 2'd1; t1 = 1;
        req_valid = 1;
        @(negedge clk);
        expect_out("R1 first of pair R11", 1'b1, 3'd2, 1'b0);
        clear_ctl(); req_el = 2'd3; t3 = 1;
        @(negedge clk);
        expect_out("R1 second of pair R11", 1'b1, 3'd4, 1'b0);
        req_valid = 0;
        @(negedge clk);
        expect_out("R1 after pair", 1'b0, 3'd0, 1'b0);
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        clear_ctl();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_nomatch();
        t_el0();
        t_first_undef();
        t_el1_order();
        t_el1_fgt();
        t_el3_last();
        t_el2();
        t_el3();
        t_back_to_back();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule